// File: doc/BRIEF.md
# Lock-Gated Debug Catch Register Access Gate

This block owns a 32-bit exception-catch control register that two agents share: software, which reaches it through a 64-bit system-register access, and an external debugger, which reads and writes it through a plain 32-bit port. For every software access, the gate decides whether the access completes, is reported as undefined, or traps to privilege level 2 or level 3. It makes that decision with a fixed, level-dependent priority chain of checks that the static configuration inputs drive.

When a software access completes, an OS lock bit decides what it does. With the lock clear, the register behaves as a location whose reads return a fixed zero pattern and whose writes are dropped. With the lock set, reads return the register and writes update it. The response has one registered cycle of latency and carries a one-hot status, the read data and the syndrome class. Delivering the exception is left to the surrounding core.

Top module: `dbg_catch_gate`

## Requirements
- R1: A request is claimed only when its encoding is op0=2'b10, op1=3'b000, CRn=4'b0000, CRm=4'b0110, op2=3'b010, for reads and writes alike. An unclaimed request produces no response (`rsp_valid` stays 0) and changes nothing.
- R2: A claimed request produces `rsp_valid` high for exactly one cycle, on the clock edge after the request. `rsp_status` is one-hot: bit0 = completed, bit1 = undefined, bit2 = trap to level 2, bit3 = trap to level 3.
- R3: A claimed request at privilege level 0 is always reported as undefined.
- R4: At level 1 the first matching check decides the outcome, in this order. (a) Undefined if level 3 is present, undefined-priority is set and the level-3 debug trap is set. (b) Trap to level 2 if level 2 is enabled, the fine-grained feature is present, fine-grained traps are enabled or level 3 is absent, and the fine-grained bit for the access direction is set. (c) Trap to level 2 if level 2 is enabled and either level-2 debug trap bit is set. (d) If level 3 is present and its debug trap is set: undefined when the secure-debug undefined flag is set, otherwise trap to level 3. (e) Otherwise the access completes.
- R5: At level 2 only checks (a) and (d) of R4 apply, in that order. Otherwise the access completes.
- R6: At level 3 every claimed access completes, whatever the trap configuration.
- R7: With the OS lock at 0, a completed read returns all zeros and a completed write leaves the register unchanged.
- R8: With the OS lock at 1, a completed read returns the register in bits 31:0 and zero in bits 63:32. A completed write loads the register from write-data bits 31:0 and ignores bits 63:32.
- R9: A trap response carries syndrome class 6'h18. Completed and undefined responses carry 0. Every response other than a completed read carries zero read data.
- R10: Check (b) uses the fine-grained read-trap bit for reads and the fine-grained write-trap bit for writes. The bit for the other direction has no effect.
- R11: The register resets to zero and `ext_rd_data` always shows its current value. An external write updates it at the next edge and takes priority over a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle software access request |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Software write data |
| cur_el | input | 2 | Current privilege level 0..3 |
| cfg_el3_present | input | 1 | Level 3 is implemented |
| cfg_el2_enabled | input | 1 | Level 2 is enabled |
| cfg_fgt_present | input | 1 | Fine-grained trap feature is implemented |
| cfg_fgt_enable | input | 1 | Fine-grained traps are enabled by level 3 |
| cfg_fgt_rd_trap | input | 1 | Fine-grained trap for reads |
| cfg_fgt_wr_trap | input | 1 | Fine-grained trap for writes |
| cfg_el2_tde | input | 1 | Level-2 debug exception routing bit |
| cfg_el2_tda | input | 1 | Level-2 debug access trap bit |
| cfg_el3_tda | input | 1 | Level-3 debug access trap bit |
| cfg_sdd_undef_prio | input | 1 | Secure-debug undefined takes priority |
| cfg_sdd_undef | input | 1 | Level-3 debug trap becomes undefined |
| cfg_os_lock | input | 1 | OS lock |
| ext_wr_en | input | 1 | External debugger write strobe |
| ext_wr_data | input | 32 | External debugger write data |
| ext_rd_data | output | 32 | Current register value |
| rsp_valid | output | 1 | Response valid |
| rsp_status | output | 4 | One-hot status {trap3, trap2, undef, ok} |
| rsp_ec | output | 6 | Syndrome class |
| rsp_rdata | output | 64 | Read data |

## Verification
Each software response is due on the rising edge after the request edge. The bench drives requests on falling edges and samples them on the following falling edge, half a cycle after the response register loads. A register update from either port becomes visible on `ext_rd_data` after the same single edge, so the register checks sample on the falling edge after the write strobe has been dropped. Unclaimed requests are checked at that same falling edge for an absent response. Every claimed request pushes exactly one expected item, so any stray or missing response shows up as a scoreboard mismatch.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;
  localparam logic [1:0] ENC_OP0 = 2'b10;
  localparam logic [2:0] ENC_OP1 = 3'b000;
  localparam logic [3:0] ENC_CRN = 4'b0000;
  localparam logic [3:0] ENC_CRM = 4'b0110;
  localparam logic [2:0] ENC_OP2 = 3'b010;

  localparam int EC_W = 6;
  localparam logic [EC_W-1:0] EC_DEBUG_TRAP = 6'h18;

  typedef enum logic [3:0] {
    ST_OK    = 4'b0001,
    ST_UNDEF = 4'b0010,
    ST_TRAP2 = 4'b0100,
    ST_TRAP3 = 4'b1000
  } gate_status_e;

  typedef struct packed {
    logic el3_present;
    logic el2_enabled;
    logic fgt_present;
    logic fgt_enable;
    logic fgt_rd_trap;
    logic fgt_wr_trap;
    logic el2_tde;
    logic el2_tda;
    logic el3_tda;
    logic sdd_undef_prio;
    logic sdd_undef;
  } trap_cfg_t;
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import dbg_gate_pkg::*;
(
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit
);
  always_comb begin
    hit = (op0 == ENC_OP0) && (op1 == ENC_OP1) && (crn == ENC_CRN) &&
          (crm == ENC_CRM) && (op2 == ENC_OP2);
  end
endmodule

// File: rtl/access_arbiter.sv
module access_arbiter
  import dbg_gate_pkg::*;
(
  input  logic [1:0]   el,
  input  logic         is_write,
  input  trap_cfg_t    cfg,
  output gate_status_e status
);
  logic l3_prio_undef;
  logic fgt_hit;
  logic l2_debug_hit;
  logic l3_debug_hit;
  gate_status_e l3_outcome;

  always_comb begin
    l3_prio_undef = cfg.el3_present && cfg.sdd_undef_prio && cfg.el3_tda;
    fgt_hit       = cfg.el2_enabled && cfg.fgt_present &&
                    (cfg.fgt_enable || !cfg.el3_present) &&
                    (is_write ? cfg.fgt_wr_trap : cfg.fgt_rd_trap);
    l2_debug_hit  = cfg.el2_enabled && (cfg.el2_tde || cfg.el2_tda);
    l3_debug_hit  = cfg.el3_present && cfg.el3_tda;
    l3_outcome    = cfg.sdd_undef ? ST_UNDEF : ST_TRAP3;
  end

  always_comb begin
    status = ST_OK;
    unique case (el)
      2'd0: status = ST_UNDEF;
      2'd1: begin
        if (l3_prio_undef)     status = ST_UNDEF;
        else if (fgt_hit)      status = ST_TRAP2;
        else if (l2_debug_hit) status = ST_TRAP2;
        else if (l3_debug_hit) status = l3_outcome;
        else                   status = ST_OK;
      end
      2'd2: begin
        if (l3_prio_undef)     status = ST_UNDEF;
        else if (l3_debug_hit) status = l3_outcome;
        else                   status = ST_OK;
      end
      default: status = ST_OK;
    endcase
  end
endmodule

// File: rtl/catch_reg.sv
module catch_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sw_we,
  input  logic [W-1:0] sw_wdata,
  input  logic         ext_we,
  input  logic [W-1:0] ext_wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (ext_we) q <= ext_wdata;
    else if (sw_we)  q <= sw_wdata;
  end

  a_r11_ext_wins: assert property (@(posedge clk) disable iff (rst)
    ext_we |=> (q == $past(ext_wdata)));
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!ext_we && !sw_we) |=> $stable(q));
endmodule

// File: rtl/dbg_catch_gate.sv
module dbg_catch_gate
  import dbg_gate_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_op0,
  input  logic [2:0]       req_op1,
  input  logic [3:0]       req_crn,
  input  logic [3:0]       req_crm,
  input  logic [2:0]       req_op2,
  input  logic             req_write,
  input  logic [XLEN-1:0]  req_wdata,
  input  logic [1:0]       cur_el,
  input  logic             cfg_el3_present,
  input  logic             cfg_el2_enabled,
  input  logic             cfg_fgt_present,
  input  logic             cfg_fgt_enable,
  input  logic             cfg_fgt_rd_trap,
  input  logic             cfg_fgt_wr_trap,
  input  logic             cfg_el2_tde,
  input  logic             cfg_el2_tda,
  input  logic             cfg_el3_tda,
  input  logic             cfg_sdd_undef_prio,
  input  logic             cfg_sdd_undef,
  input  logic             cfg_os_lock,
  input  logic             ext_wr_en,
  input  logic [REG_W-1:0] ext_wr_data,
  output logic [REG_W-1:0] ext_rd_data,
  output logic             rsp_valid,
  output logic [3:0]       rsp_status,
  output logic [EC_W-1:0]  rsp_ec,
  output logic [XLEN-1:0]  rsp_rdata
);
  localparam int PAD_W = XLEN - REG_W;

  logic         enc_hit;
  logic         claimed;
  gate_status_e status;
  trap_cfg_t    cfg;
  logic         sw_we;
  logic [REG_W-1:0] reg_q;
  logic [XLEN-1:0]  rdata_n;
  logic [EC_W-1:0]  ec_n;

  always_comb begin
    cfg.el3_present    = cfg_el3_present;
    cfg.el2_enabled    = cfg_el2_enabled;
    cfg.fgt_present    = cfg_fgt_present;
    cfg.fgt_enable     = cfg_fgt_enable;
    cfg.fgt_rd_trap    = cfg_fgt_rd_trap;
    cfg.fgt_wr_trap    = cfg_fgt_wr_trap;
    cfg.el2_tde        = cfg_el2_tde;
    cfg.el2_tda        = cfg_el2_tda;
    cfg.el3_tda        = cfg_el3_tda;
    cfg.sdd_undef_prio = cfg_sdd_undef_prio;
    cfg.sdd_undef      = cfg_sdd_undef;
  end

  sysreg_decode u_decode (
    .op0 (req_op0),
    .op1 (req_op1),
    .crn (req_crn),
    .crm (req_crm),
    .op2 (req_op2),
    .hit (enc_hit)
  );

  access_arbiter u_arb (
    .el       (cur_el),
    .is_write (req_write),
    .cfg      (cfg),
    .status   (status)
  );

  always_comb begin
    claimed = req_valid && enc_hit;
    sw_we   = claimed && req_write && (status == ST_OK) && cfg_os_lock;
    rdata_n = '0;
    if (claimed && !req_write && (status == ST_OK) && cfg_os_lock)
      rdata_n = {{PAD_W{1'b0}}, reg_q};
    ec_n = ((status == ST_TRAP2) || (status == ST_TRAP3)) ? EC_DEBUG_TRAP : '0;
  end

  catch_reg #(.W(REG_W)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .sw_we     (sw_we),
    .sw_wdata  (req_wdata[REG_W-1:0]),
    .ext_we    (ext_wr_en),
    .ext_wdata (ext_wr_data),
    .q         (reg_q)
  );

  assign ext_rd_data = reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      rsp_ec     <= '0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid  <= claimed;
      rsp_status <= claimed ? status : 4'b0000;
      rsp_ec     <= claimed ? ec_n : '0;
      rsp_rdata  <= rdata_n;
    end
  end

  a_r1_unclaimed_silent: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !enc_hit) |=> !rsp_valid);
  a_r2_status_onehot: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones(rsp_status) == 1));
  a_r3_el0_undef: assert property (@(posedge clk) disable iff (rst)
    (claimed && cur_el == 2'd0) |=> (rsp_status == ST_UNDEF));
  a_r6_el3_ok: assert property (@(posedge clk) disable iff (rst)
    (claimed && cur_el == 2'd3) |=> (rsp_status == ST_OK));
  a_r7_unlocked_write_drop: assert property (@(posedge clk) disable iff (rst)
    (claimed && req_write && !cfg_os_lock && !ext_wr_en) |=> $stable(ext_rd_data));
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_rdata[XLEN-1:REG_W] == '0));
  a_r9_trap_class: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_status[2] || rsp_status[3])) |-> (rsp_ec == EC_DEBUG_TRAP));
endmodule

// File: tb/dbg_catch_gate_bench.sv
module dbg_catch_gate_bench;
  logic clk = 1'b0;
  logic rst;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_op0 = 0, cur_el = 0;
  logic [2:0]  req_op1 = 0, req_op2 = 0;
  logic [3:0]  req_crn = 0, req_crm = 0;
  logic [63:0] req_wdata = 0;
  logic c_el3 = 0, c_el2 = 0, c_fgtp = 0, c_fgte = 0, c_fgtr = 0, c_fgtw = 0;
  logic c_tde = 0, c_tda2 = 0, c_tda3 = 0, c_prio = 0, c_sdd = 0, c_lock = 0;
  logic        ext_wr_en = 0;
  logic [31:0] ext_wr_data = 0;
  logic [31:0] ext_rd_data;
  logic        rsp_valid;
  logic [3:0]  rsp_status;
  logic [5:0]  rsp_ec;
  logic [63:0] rsp_rdata;

  dbg_catch_gate u_dbg_catch_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
    .req_op2(req_op2), .req_write(req_write), .req_wdata(req_wdata), .cur_el(cur_el),
    .cfg_el3_present(c_el3), .cfg_el2_enabled(c_el2), .cfg_fgt_present(c_fgtp),
    .cfg_fgt_enable(c_fgte), .cfg_fgt_rd_trap(c_fgtr), .cfg_fgt_wr_trap(c_fgtw),
    .cfg_el2_tde(c_tde), .cfg_el2_tda(c_tda2), .cfg_el3_tda(c_tda3),
    .cfg_sdd_undef_prio(c_prio), .cfg_sdd_undef(c_sdd), .cfg_os_lock(c_lock),
    .ext_wr_en(ext_wr_en), .ext_wr_data(ext_wr_data), .ext_rd_data(ext_rd_data),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_ec(rsp_ec), .rsp_rdata(rsp_rdata)
  );

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] model_reg = 0;
  logic [73:0] exp_q[$];
  string       tag_q[$];

  // status encoding: 1=ok 2=undef 4=trap2 8=trap3
  function automatic logic [3:0] model_status(input logic [1:0] el, input logic wr);
    logic prio, fgt, l2, l3;
    logic [3:0] l3o;
    prio = c_el3 && c_prio && c_tda3;
    fgt  = c_el2 && c_fgtp && (c_fgte || !c_el3) && (wr ? c_fgtw : c_fgtr);
    l2   = c_el2 && (c_tde || c_tda2);
    l3   = c_el3 && c_tda3;
    l3o  = c_sdd ? 4'd2 : 4'd8;
    if (el == 0) return 4'd2;
    if (el == 3) return 4'd1;
    if (prio) return 4'd2;
    if (el == 1 && fgt) return 4'd4;
    if (el == 1 && l2) return 4'd4;
    if (l3) return l3o;
    return 4'd1;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input string tag, input logic [1:0] el, input logic wr,
                        input logic [63:0] data);
    logic [3:0] st;
    logic [5:0] ec;
    logic [63:0] rd;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_wdata = data; cur_el = el;
    req_op0 = 2'b10; req_op1 = 3'b000; req_crn = 4'b0000; req_crm = 4'b0110; req_op2 = 3'b010;
    st = model_status(el, wr);
    ec = (st == 4'd4 || st == 4'd8) ? 6'h18 : 6'h00;
    rd = (st == 4'd1 && !wr && c_lock) ? {32'h0, model_reg} : 64'h0;
    if (st == 4'd1 && wr && c_lock) model_reg = data[31:0];
    exp_q.push_back({st, ec, rd});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic stray(input string tag, input logic [1:0] o0, input logic [3:0] cm,
                       input logic [2:0] o2);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_wdata = 64'hDEAD_BEEF_DEAD_BEEF; cur_el = 3;
    req_op0 = o0; req_op1 = 3'b000; req_crn = 4'b0000; req_crm = cm; req_op2 = o2;
    @(negedge clk);
    req_valid = 0;
    check({tag, " rsp_valid"}, {63'h0, rsp_valid}, 64'h0);
    check({tag, " reg"}, {32'h0, ext_rd_data}, {32'h0, model_reg});
  endtask

  task automatic ext_write(input logic [31:0] v);
    @(negedge clk);
    ext_wr_en = 1; ext_wr_data = v;
    model_reg = v;
    @(negedge clk);
    ext_wr_en = 0;
  endtask

  task automatic clear_cfg();
    {c_el3, c_el2, c_fgtp, c_fgte, c_fgtr, c_fgtw, c_tde, c_tda2, c_tda3, c_prio, c_sdd} = '0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL R2: unexpected response actual %h expected none", rsp_status);
      end else begin
        logic [73:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " status"}, {60'h0, rsp_status}, {60'h0, e[73:70]});
        check({t, " ec R9"}, {58'h0, rsp_ec}, {58'h0, e[69:64]});
        check({t, " rdata"}, rsp_rdata, e[63:0]);
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R11 reset reg", {32'h0, ext_rd_data}, 64'h0);
    check("R2 reset valid", {63'h0, rsp_valid}, 64'h0);

    // R8: locked write at level 3, upper half ignored
    c_lock = 1;
    access("R8 el3 write", 3, 1, 64'hFFFF_FFFF_A5A5_1234);
    check("R8 reg after write", {32'h0, ext_rd_data}, 64'h0000_0000_A5A5_1234);
    access("R8 el3 read", 3, 0, 64'h0);

    access("R3 el0 read", 0, 0, 64'h0);
    access("R3 el0 write", 0, 1, 64'h1111);
    access("R4 el1 clear read", 1, 0, 64'h0);

    // R4 (a) beats fine-grained
    c_el3 = 1; c_prio = 1; c_tda3 = 1; c_el2 = 1; c_fgtp = 1; c_fgte = 1; c_fgtr = 1;
    access("R4 prio undef", 1, 0, 64'h0);
    access("R5 prio undef el2", 2, 0, 64'h0);
    c_prio = 0;
    access("R10 fgt read trap", 1, 0, 64'h0);
    access("R10 fgt rd bit ignored on write", 1, 1, 64'h2222);
    clear_cfg(); c_el2 = 1; c_fgtp = 1; c_fgtw = 1; c_el3 = 1;
    access("R10 fgt gated by enable", 1, 1, 64'h3333);
    c_el3 = 0;
    access("R10 fgt write trap el3 absent", 1, 1, 64'h4444);
    clear_cfg(); c_el2 = 1; c_tde = 1;
    access("R4 el2 tde trap", 1, 0, 64'h0);
    c_tde = 0; c_tda2 = 1; c_el3 = 1; c_tda3 = 1;
    access("R4 el2 tda before el3", 1, 0, 64'h0);
    access("R5 el2 ignores el2 bits", 2, 0, 64'h0);
    c_tda2 = 0;
    access("R4 el3 trap", 1, 1, 64'h5555);
    c_sdd = 1;
    access("R4 sdd undef", 1, 0, 64'h0);
    access("R5 sdd undef el2", 2, 1, 64'h6666);
    clear_cfg(); c_el2 = 1; c_tde = 1; c_fgtp = 1; c_fgtr = 1;
    access("R5 el2 ok", 2, 1, 64'h0000_0001_7777_0000);
    {c_el3, c_el2, c_fgtp, c_fgte, c_fgtr, c_fgtw, c_tde, c_tda2, c_tda3, c_prio, c_sdd} = '1;
    access("R6 el3 ok read", 3, 0, 64'h0);
    clear_cfg();

    // R7 lock clear
    c_lock = 0;
    access("R7 unlocked write", 3, 1, 64'h0000_0000_9999_8888);
    check("R7 reg unchanged", {32'h0, ext_rd_data}, {32'h0, model_reg});
    access("R7 unlocked read", 1, 0, 64'h0);
    c_lock = 1;

    stray("R1 bad crm", 2'b10, 4'b0111, 3'b010);
    stray("R1 bad op2", 2'b10, 4'b0110, 3'b000);
    stray("R1 bad op0", 2'b11, 4'b0110, 3'b010);

    // R11 external port
    ext_write(32'hC0DE_0042);
    check("R11 ext write", {32'h0, ext_rd_data}, 64'h0000_0000_C0DE_0042);
    access("R11 read after ext", 3, 0, 64'h0);
    // collision: external wins
    @(negedge clk);
    req_valid = 1; req_write = 1; req_wdata = 64'h1234_5678; cur_el = 3;
    req_op0 = 2'b10; req_op1 = 3'b000; req_crn = 4'b0000; req_crm = 4'b0110; req_op2 = 3'b010;
    ext_wr_en = 1; ext_wr_data = 32'hFEED_F00D;
    exp_q.push_back({4'd1, 6'h00, 64'h0});
    tag_q.push_back("R11 collision rsp");
    model_reg = 32'hFEED_F00D;
    @(negedge clk);
    req_valid = 0; ext_wr_en = 0;
    check("R11 ext wins", {32'h0, ext_rd_data}, 64'h0000_0000_FEED_F00D);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fails++;
      $display("FAIL R2: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule